// File: doc/BRIEF.md
# VLAN Table Command Sequencer

This block programs the VLAN translation unit of a switch through a simple register-bus master. A local table of VLAN entries, each a 12-bit VLAN identifier and a membership mask over six ports, is filled through a write port. A `start` pulse launches the sequence. The block first issues a flush command. It then walks the table in ascending index order and issues one load command for every entry whose membership mask is not zero.

Every command is gated by a busy handshake. The block reads the command register until its active bit reads 0. It tolerates a bounded number of busy reads, then aborts with an error. A load writes the data register, holding the members and a valid flag, before it writes the command word. Writing the command word with its active bit set starts the operation in the translation unit.

As a side effect of loading, the block builds one destination mask per port. Each mask holds the other members of every loaded entry that contains that port. These masks are published as a flat output.

Top module: `vtuLoaderTop`

## Requirements
- R1: During and after reset, `done`, `err` and `busValid` are 0, and every bit of `portReach` is 0.
- R2: After `start`, the first register write of the sequence is to the command register (address 0x40). It carries op code 1 (flush) in bits [2:0] and the active bit (bit 3), with all other bits 0. No data-register write comes before it.
- R3: Before each command write, the command register is read until a read returns active bit 3 at 0. With b busy reads before an idle one, that command costs exactly b+1 reads.
- R4: Up to 20 consecutive busy reads are tolerated. On the 21st, the sequence aborts: no further bus writes, and `done`=1 with `err`=1.
- R5: A load first writes the data register (address 0x44) with the entry's members in bits [5:0] and the valid flag in bit 11, all other bits 0. The very next bus transfer is the command write.
- R6: Every command write has bit 3 set. A load command carries op code 2 in bits [2:0] and the entry's VLAN identifier in bits [27:16], with all other bits 0.
- R7: Entries with an all-zero membership mask produce no bus traffic. Loads follow ascending table index, and the table holds 128 entries (index 0 to 127).
- R8: `portReach[p*6 +: 6]` ends as the OR, over all loaded entries that contain port p, of that entry's members with bit p removed.
- R9: While `busValid` is high and `busReady` is low, `busValid`, `busWrite`, `busAddr` and `busWdata` hold their values.
- R10: A new `start` clears `done`, `err` and all `portReach` masks, so a rerun reflects only the current table. While `done` is high, `busValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the sequence (taken when idle) |
| tblWe | input | 1 | Table entry write enable |
| tblIdx | input | 7 | Table entry index |
| tblVid | input | 12 | VLAN identifier to store |
| tblMembers | input | 6 | Port membership mask to store |
| busValid | output | 1 | Bus transfer request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busAddr | output | 8 | Register address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid with busReady on a read |
| busReady | input | 1 | Transfer accepted this cycle |
| done | output | 1 | Sequence finished (level until next start) |
| err | output | 1 | Sequence aborted on busy timeout |
| portReach | output | 36 | Per-port destination masks, port p at [p*6 +: 6] |

## Verification
The bench's register model keeps the active bit high for a set number of reads after each command. It drives exactly 20 and exactly 21 busy reads, both before the flush and before a load. An off-by-one in the retry counter therefore shows up either as a false timeout or as a missed abort with stray writes. A sweep over all 64 membership values checks that empty entries are skipped and that the data and command words are exact. A sparse table run after a full one checks the mask arithmetic: a design that dropped the self-exclusion or failed to clear masks at start would report stale or self-reaching ports. A stalling ready signal exposes a master that changes its request before acceptance.

// File: rtl/vtuLoaderPkg.sv
package vtuLoaderPkg;
  typedef enum logic [1:0] {BUS_NONE, BUS_RDCMD, BUS_WRDATA, BUS_WRCMD} busOp_e;

  typedef struct packed {
    busOp_e busOp;
    logic   isLoad;
    logic   clrAll;
    logic   accum;
    logic   ptrInc;
    logic   retryInc;
    logic   retryClr;
  } strobes_t;

  localparam logic [2:0] OP_FLUSH = 3'd1;
  localparam logic [2:0] OP_LOAD  = 3'd2;
endpackage

// File: rtl/vtuLoaderPath.sv
module vtuLoaderPath
  import vtuLoaderPkg::*;
#(
  parameter int NPORTS      = 6,
  parameter int NENTRIES    = 128,
  parameter int VID_W       = 12,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h40,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h44,
  parameter int VID_LSB     = 16,
  parameter int VALID_BIT   = 11,
  parameter int MEMB_LSB    = 0,
  parameter int RETRY_LIMIT = 20,
  localparam int IDX_W      = $clog2(NENTRIES),
  localparam int RETRY_W    = $clog2(RETRY_LIMIT + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tblWe,
  input  logic [IDX_W-1:0]         tblIdx,
  input  logic [VID_W-1:0]         tblVid,
  input  logic [NPORTS-1:0]        tblMembers,
  input  strobes_t                 strb,
  output logic                     entryEmpty,
  output logic                     ptrLast,
  output logic                     retryAtLimit,
  output logic [ADDR_W-1:0]        busAddr,
  output logic [DATA_W-1:0]        busWdata,
  output logic [NPORTS*NPORTS-1:0] portReach
);
  logic [VID_W-1:0]  vidMem [NENTRIES];
  logic [NPORTS-1:0] memMem [NENTRIES];
  logic [IDX_W-1:0]  ptr;
  logic [RETRY_W-1:0] retryCnt;
  logic [VID_W-1:0]  curVid;
  logic [NPORTS-1:0] curMem;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NENTRIES; e++) begin
        vidMem[e] <= '0;
        memMem[e] <= '0;
      end
    end else if (tblWe) begin
      vidMem[tblIdx] <= tblVid;
      memMem[tblIdx] <= tblMembers;
    end
  end

  assign curVid     = vidMem[ptr];
  assign curMem     = memMem[ptr];
  assign entryEmpty = (curMem == '0);
  assign ptrLast    = (ptr == IDX_W'(NENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrAll) ptr <= '0;
    else if (strb.ptrInc)     ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.retryClr) retryCnt <= '0;
    else if (strb.retryInc)     retryCnt <= retryCnt + 1'b1;
  end
  assign retryAtLimit = (retryCnt == RETRY_W'(RETRY_LIMIT));

  for (genvar p = 0; p < NPORTS; p++) begin : g_reach
    logic [NPORTS-1:0] reach;
    always_ff @(posedge clk) begin
      if (!rstN || strb.clrAll) reach <= '0;
      else if (strb.accum && curMem[p])
        reach <= reach | (curMem & ~(NPORTS'(1) << p));
    end
    assign portReach[p*NPORTS +: NPORTS] = reach;
  end

  always_comb begin
    busAddr  = CMD_ADDR;
    busWdata = '0;
    case (strb.busOp)
      BUS_WRDATA: begin
        busAddr = DATA_ADDR;
        busWdata[MEMB_LSB +: NPORTS] = curMem;
        busWdata[VALID_BIT] = 1'b1;
      end
      BUS_WRCMD: begin
        busWdata[2:0] = strb.isLoad ? OP_LOAD : OP_FLUSH;
        if (strb.isLoad) busWdata[VID_LSB +: VID_W] = curVid;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vtuLoaderCtrl.sv
module vtuLoaderCtrl
  import vtuLoaderPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     busReady,
  input  logic     cmdBusy,
  input  logic     entryEmpty,
  input  logic     ptrLast,
  input  logic     retryAtLimit,
  output strobes_t strb,
  output logic     busValid,
  output logic     busWrite,
  output logic     done,
  output logic     err
);
  typedef enum logic [2:0] {S_IDLE, S_POLL, S_WDATA, S_WCMD, S_SCAN} state_e;
  state_e state, stateNext;
  logic opLoad, setLoad, finish, abort, launch;

  always_comb begin
    strb        = '0;
    strb.isLoad = opLoad;
    stateNext   = state;
    setLoad     = 1'b0;
    finish      = 1'b0;
    abort       = 1'b0;
    launch      = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        launch        = 1'b1;
        strb.clrAll   = 1'b1;
        strb.retryClr = 1'b1;
        stateNext     = S_POLL;
      end
      S_POLL: begin
        strb.busOp = BUS_RDCMD;
        if (busReady) begin
          if (cmdBusy) begin
            if (retryAtLimit) begin
              abort     = 1'b1;
              stateNext = S_IDLE;
            end else strb.retryInc = 1'b1;
          end else begin
            strb.retryClr = 1'b1;
            stateNext     = opLoad ? S_WDATA : S_WCMD;
          end
        end
      end
      S_WDATA: begin
        strb.busOp = BUS_WRDATA;
        if (busReady) stateNext = S_WCMD;
      end
      S_WCMD: begin
        strb.busOp = BUS_WRCMD;
        if (busReady) begin
          if (!opLoad) stateNext = S_SCAN;
          else if (ptrLast) begin
            finish    = 1'b1;
            stateNext = S_IDLE;
          end else begin
            strb.ptrInc = 1'b1;
            stateNext   = S_SCAN;
          end
        end
      end
      S_SCAN: begin
        if (entryEmpty) begin
          if (ptrLast) begin
            finish    = 1'b1;
            stateNext = S_IDLE;
          end else strb.ptrInc = 1'b1;
        end else begin
          strb.accum    = 1'b1;
          strb.retryClr = 1'b1;
          setLoad       = 1'b1;
          stateNext     = S_POLL;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opLoad <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      state <= stateNext;
      if (launch) begin
        opLoad <= 1'b0;
        done   <= 1'b0;
        err    <= 1'b0;
      end else if (setLoad) opLoad <= 1'b1;
      if (finish) done <= 1'b1;
      if (abort) begin
        done <= 1'b1;
        err  <= 1'b1;
      end
    end
  end

  assign busValid = (state == S_POLL) || (state == S_WDATA) || (state == S_WCMD);
  assign busWrite = (state == S_WDATA) || (state == S_WCMD);
endmodule

// File: rtl/vtuLoaderTop.sv
module vtuLoaderTop
  import vtuLoaderPkg::*;
#(
  parameter int NPORTS      = 6,
  parameter int NENTRIES    = 128,
  parameter int VID_W       = 12,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h40,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h44,
  parameter int ACT_BIT     = 3,
  parameter int VID_LSB     = 16,
  parameter int VALID_BIT   = 11,
  parameter int MEMB_LSB    = 0,
  parameter int RETRY_LIMIT = 20,
  localparam int IDX_W      = $clog2(NENTRIES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     tblWe,
  input  logic [IDX_W-1:0]         tblIdx,
  input  logic [VID_W-1:0]         tblVid,
  input  logic [NPORTS-1:0]        tblMembers,
  output logic                     busValid,
  output logic                     busWrite,
  output logic [ADDR_W-1:0]        busAddr,
  output logic [DATA_W-1:0]        busWdata,
  input  logic [DATA_W-1:0]        busRdata,
  input  logic                     busReady,
  output logic                     done,
  output logic                     err,
  output logic [NPORTS*NPORTS-1:0] portReach
);
  strobes_t strb;
  logic entryEmpty, ptrLast, retryAtLimit, cmdBusy;
  logic [DATA_W-1:0] unusedRdata;

  assign cmdBusy     = busRdata[ACT_BIT];
  assign unusedRdata = busRdata;

  vtuLoaderCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busReady(busReady),
    .cmdBusy(cmdBusy), .entryEmpty(entryEmpty), .ptrLast(ptrLast),
    .retryAtLimit(retryAtLimit), .strb(strb), .busValid(busValid),
    .busWrite(busWrite), .done(done), .err(err)
  );

  logic [DATA_W-1:0] rawWdata;

  vtuLoaderPath #(
    .NPORTS(NPORTS), .NENTRIES(NENTRIES), .VID_W(VID_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR),
    .VID_LSB(VID_LSB), .VALID_BIT(VALID_BIT), .MEMB_LSB(MEMB_LSB),
    .RETRY_LIMIT(RETRY_LIMIT)
  ) u_path (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblIdx(tblIdx), .tblVid(tblVid),
    .tblMembers(tblMembers), .strb(strb), .entryEmpty(entryEmpty),
    .ptrLast(ptrLast), .retryAtLimit(retryAtLimit), .busAddr(busAddr),
    .busWdata(rawWdata), .portReach(portReach)
  );

  // the command word always carries the active bit, which starts the operation
  always_comb begin
    busWdata = rawWdata;
    if (strb.busOp == BUS_WRCMD) busWdata[ACT_BIT] = 1'b1;
  end
endmodule

// File: rtl/vtuLoaderChk.sv
module vtuLoaderChk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h40,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h44,
  parameter int ACT_BIT   = 3,
  parameter int VALID_BIT = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busReady,
  input logic              done,
  input logic              err
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !busValid && !done && !err);

  p_hold_request_r9: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busWrite) && $stable(busAddr) && $stable(busWdata));

  p_err_with_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  p_cmd_active_r6: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busAddr == CMD_ADDR |-> busWdata[ACT_BIT]);

  p_data_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busWrite && busAddr == DATA_ADDR |-> busWdata[VALID_BIT]);

  p_data_then_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady && busWrite && busAddr == DATA_ADDR |=>
      busValid && busWrite && busAddr == CMD_ADDR);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busValid);
endmodule

bind vtuLoaderTop vtuLoaderChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR),
  .ACT_BIT(ACT_BIT), .VALID_BIT(VALID_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
  .done(done), .err(err)
);

// File: tb/test_vtuLoaderTop.sv
module test_vtuLoaderTop;
  localparam int NP = 6;
  localparam int NE = 128;
  localparam logic [7:0] CMDA = 8'h40;
  localparam logic [7:0] DATA = 8'h44;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic tblWe = 1'b0;
  logic [6:0] tblIdx = '0;
  logic [11:0] tblVid = '0;
  logic [5:0] tblMembers = '0;
  logic busValid, busWrite, done, err, busReady;
  logic [7:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [NP*NP-1:0] portReach;

  always #10 clk = ~clk;

  vtuLoaderTop i_vtuLoaderTop (
    .clk(clk), .rstN(rstN), .start(start), .tblWe(tblWe), .tblIdx(tblIdx),
    .tblVid(tblVid), .tblMembers(tblMembers), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .done(done), .err(err),
    .portReach(portReach)
  );

  // register model
  int busyLeft = 0;
  int busyPerCmd = 0;
  int readCount = 0;
  int wrCount = 0;
  logic [7:0]  wrAddr [512];
  logic [31:0] wrData [512];
  bit stallMode = 0;
  bit stallTog = 0;

  assign busReady = stallMode ? stallTog : 1'b1;
  assign busRdata = (busyLeft > 0) ? 32'h8 : 32'h0;

  always @(negedge clk) stallTog <= ~stallTog;

  always @(posedge clk) begin
    if (rstN && busValid && busReady) begin
      if (!busWrite) begin
        readCount <= readCount + 1;
        if (busyLeft > 0) busyLeft <= busyLeft - 1;
      end else begin
        if (wrCount < 512) begin
          wrAddr[wrCount] <= busAddr;
          wrData[wrCount] <= busWdata;
        end
        wrCount <= wrCount + 1;
        if (busAddr == CMDA) busyLeft <= busyPerCmd;
      end
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int mVid [NE];
  int mMem [NE];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic putEntry(input int idx, input int vid, input int mem);
    @(negedge clk);
    tblWe = 1'b1; tblIdx = 7'(idx); tblVid = 12'(vid); tblMembers = 6'(mem);
    mVid[idx] = vid; mMem[idx] = mem;
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic clearTable();
    for (int e = 0; e < NE; e++) putEntry(e, 0, 0);
  endtask

  task automatic runSeq(input int initBusy, input int perCmd);
    @(negedge clk);
    wrCount = 0; readCount = 0; busyLeft = initBusy; busyPerCmd = perCmd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && err == 1'b0, "R10 start clears done/err", {done, err}, 0);
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
  endtask

  // compare the whole write log and read count against the table model
  task automatic checkSequence(input int initBusy, input int perCmd, input string tag);
    logic [31:0] expData [512];
    logic [7:0]  expAddr [512];
    int n = 0;
    int loads = 0;
    int wrong = 0;
    logic [5:0] expReach [NP];
    for (int p = 0; p < NP; p++) expReach[p] = '0;
    expAddr[0] = CMDA; expData[0] = 32'h9; n = 1;
    for (int e = 0; e < NE; e++) begin
      if (mMem[e] != 0) begin
        expAddr[n] = DATA; expData[n] = 32'(mMem[e]) | 32'h800; n++;
        expAddr[n] = CMDA; expData[n] = 32'h2 | 32'h8 | (32'(mVid[e]) << 16); n++;
        loads++;
        for (int p = 0; p < NP; p++)
          if (mMem[e][p]) expReach[p] |= 6'(mMem[e]) & ~(6'(1) << p);
      end
    end
    check(done && !err, {tag, " R4 completes without error"}, {done, err}, 2'b10);
    check(wrCount == n, {tag, " R7 write count"}, wrCount, n);
    check(wrAddr[0] == CMDA && wrData[0] == 32'h9, {tag, " R2 flush first"}, wrData[0], 32'h9);
    for (int i = 0; i < n && i < wrCount; i++)
      if (wrAddr[i] != expAddr[i] || wrData[i] != expData[i]) begin
        if (wrong == 0)
          check(0, {tag, " R5 R6 write word"}, {wrAddr[i], wrData[i]}, {expAddr[i], expData[i]});
        wrong++;
      end
    check(wrong == 0, {tag, " R6 all words match"}, wrong, 0);
    check(readCount == (initBusy + 1) + loads * (perCmd + 1), {tag, " R3 poll count"},
          readCount, (initBusy + 1) + loads * (perCmd + 1));
    for (int p = 0; p < NP; p++)
      check(portReach[p*NP +: NP] == expReach[p], {tag, " R8 port mask"},
            portReach[p*NP +: NP], expReach[p]);
  endtask

  task automatic loadSparse();
    clearTable();
    putEntry(3, 12'h123, 6'b000011);
    putEntry(10, 12'hFFF, 6'b101100);
    putEntry(40, 12'h5A5, 6'b100001);
    putEntry(127, 12'h001, 6'b000001);
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin mVid[e] = 0; mMem[e] = 0; end
    repeat (3) @(negedge clk);
    check(!done && !err && !busValid && portReach == '0, "R1 reset state",
          {done, err, busValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !err && !busValid, "R1 after reset", {done, err, busValid}, 0);

    // empty table: flush only
    runSeq(0, 0);
    checkSequence(0, 0, "empty");

    // exactly 20 busy reads tolerated before the flush
    runSeq(20, 0);
    checkSequence(20, 0, "busy20");

    // 21 busy reads before the flush abort it
    runSeq(21, 0);
    check(done && err, "R4 abort at 21st busy read", {done, err}, 2'b11);
    check(wrCount == 0, "R4 no write after abort", wrCount, 0);
    check(readCount == 21, "R4 reads before abort", readCount, 21);

    // sweep of every membership value, 20 busy reads per load
    for (int e = 0; e < 64; e++) putEntry(e, (e * 37 + 5) & 12'hFFF, e);
    runSeq(0, 20);
    checkSequence(0, 20, "sweep");

    // sparse table with stalls, after full masks: R10 clearing
    loadSparse();
    stallMode = 1;
    runSeq(2, 5);
    checkSequence(2, 5, "sparse R10");
    stallMode = 0;

    // timeout before first load
    runSeq(0, 21);
    check(done && err, "R4 abort mid sequence", {done, err}, 2'b11);
    check(wrCount == 1 && wrData[0] == 32'h9, "R4 only flush written", wrCount, 1);
    check(readCount == 22, "R4 reads before mid abort", readCount, 22);

    // rerun after error
    runSeq(1, 3);
    checkSequence(1, 3, "rerun R10");
    check(!busValid, "R10 idle after done", busValid, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule